// File: doc/BRIEF.md
# PHY presence scan engine

This block sits between the software access path of a management-bus master and the serial frame engine that drives the management clock and data lines. While the master enable is high, it keeps reading one fixed register from every PHY address in turn. It wraps from the highest address back to zero and never stops. Each read that a PHY acknowledges sets that address's bit in a live-PHY bitmap. A read that goes unanswered clears the bit. Software can therefore learn which PHYs are fitted by waiting one full pass after enable and then sampling the bitmap.

The engine and software share the single frame engine through a non-preemptive arbiter. Only one transaction is ever outstanding. When the frame engine reports completion, a pending software request wins the next slot. A software request that arrives while a scan read is on the bus waits only until that read finishes. Software transactions do not move the scan position. Each completed scan read that was acknowledged also produces a one-cycle response strobe tagged with its address.

Top module: `phy_scan_engine`

## Requirements
- R1: After synchronous reset, `live_map` is all zeros, `fe_start` is low, and with `enable` low `idle` is high.
- R2: Scan reads go to addresses 0, 1, 2, … in ascending order and wrap from NUM_ADDR-1 back to 0. Every scan read has `fe_write`=0 and `fe_reg`=SCAN_REG (default 1). Software transactions do not advance the scan position.
- R3: In the cycle after the frame engine's `fe_done` is taken for a scan read, bit [addr] of `live_map` equals that read's `fe_ack`. A set bit is therefore cleared when a later read at that address gets no answer. No bit changes at any other time.
- R4: In the cycle after an acknowledged scan read completes, `scan_resp` pulses high for one cycle and `scan_resp_addr` holds that read's address. `scan_resp` stays low for unanswered reads and for software transactions.
- R5: At most one transaction is outstanding. `fe_start` never pulses between a `fe_start` and its `fe_done`. The next `fe_start` appears one cycle after `fe_done` is taken.
- R6: A software request (`usr_req` high) seen while no transaction is outstanding wins over the next scan read.
- R7: A software request raised while a scan read is outstanding is granted right after that read completes. The wait is at most one access plus two cycles.
- R8: A software grant pulses `usr_grant` together with `fe_start`, carrying the requester's write flag, PHY address, register and write data. On its completion, `usr_done` pulses for one cycle with `usr_ack` equal to `fe_ack` and `usr_rdata` equal to `fe_rdata`.
- R9: With `enable` low, no new transaction starts and `live_map` holds its value. An outstanding transaction still completes, after which `idle` is high.
- R10: Once NUM_ADDR scan reads have completed after the presence pattern was last changed, `live_map` equals the set of responding addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Master enable; low stops new transactions |
| usr_req | input | 1 | Software request; dropped after `usr_grant` |
| usr_write | input | 1 | Software request is a write |
| usr_phy | input | 5 | Software target PHY address |
| usr_reg | input | 5 | Software target register |
| usr_wdata | input | DATA_W | Software write data |
| usr_grant | output | 1 | Software request issued to the frame engine |
| usr_done | output | 1 | Software transaction finished |
| usr_ack | output | 1 | PHY answered the software transaction |
| usr_rdata | output | DATA_W | Software read data |
| fe_start | output | 1 | Start pulse to the frame engine |
| fe_write | output | 1 | Transaction is a write |
| fe_phy | output | 5 | Transaction PHY address |
| fe_reg | output | 5 | Transaction register |
| fe_wdata | output | DATA_W | Transaction write data |
| fe_done | input | 1 | Frame engine completion pulse |
| fe_ack | input | 1 | PHY answered, valid with `fe_done` |
| fe_rdata | input | DATA_W | Read data, valid with `fe_done` |
| live_map | output | NUM_ADDR | One bit per PHY address, set when it answered |
| scan_resp | output | 1 | Acknowledged scan read strobe |
| scan_resp_addr | output | $clog2(NUM_ADDR) | Address of the strobed scan read |
| idle | output | 1 | Disabled and nothing outstanding |

## Verification
The bench uses the default parameters: NUM_ADDR=32, DATA_W=16 and SCAN_REG=1. It models a frame engine with a three-cycle access. At the full 32-address width, both ends of the bitmap, bit 0 and bit 31, and the wrap from 31 back to 0 are exercised and checked. Three cases are set up deliberately:
- a software request raised just after a scan read has started, to measure the deferral;
- a request raised in the same cycle a software transaction finishes, to check priority;
- a presence pattern that drops and adds PHYs, so that set bits are cleared.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int PHY_W = 5;
    localparam int REG_W = 5;

    // Who owns the frame engine right now
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SCAN = 2'd1,
        SRC_USER = 2'd2
    } src_e;

    // Command header carried to the frame engine
    typedef struct packed {
        logic             wr;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
    } cmd_t;

    function automatic cmd_t scan_cmd(logic [PHY_W-1:0] phy, logic [REG_W-1:0] regad);
        cmd_t c;
        c.wr    = 1'b0;
        c.phy   = phy;
        c.regad = regad;
        return c;
    endfunction

endpackage

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
    parameter int NUM_ADDR = 32,
    localparam int AW = $clog2(NUM_ADDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] LAST = AW'(NUM_ADDR - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (step) begin
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
        end
    end

endmodule

// File: rtl/live_bitmap.sv
module live_bitmap #(
    parameter int NUM_ADDR = 32,
    localparam int AW = $clog2(NUM_ADDR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  logic [AW-1:0]       idx,
    input  logic                hit,
    output logic [NUM_ADDR-1:0] bits
);

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                bits[i] <= 1'b0;
            end else if (upd && idx == AW'(i)) begin
                bits[i] <= hit;
            end
        end
    end

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import phy_scan_pkg::*;
#(
    parameter int NUM_ADDR = 32,
    parameter int DATA_W = 16,
    parameter logic [REG_W-1:0] SCAN_REG = 5'd1,
    localparam int AW = $clog2(NUM_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              usr_req,
    input  cmd_t              usr_cmd,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic [AW-1:0]     scan_addr,
    input  logic              fe_done,
    output logic              fe_start,
    output cmd_t              fe_cmd,
    output logic [DATA_W-1:0] fe_wdata,
    output logic              usr_grant,
    output src_e              owner
);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner     <= SRC_NONE;
            fe_start  <= 1'b0;
            usr_grant <= 1'b0;
            fe_cmd    <= '0;
            fe_wdata  <= '0;
        end else begin
            fe_start  <= 1'b0;
            usr_grant <= 1'b0;
            case (owner)
                SRC_NONE: begin
                    if (enable) begin
                        fe_start <= 1'b1;
                        if (usr_req) begin
                            // software wins whenever the bus is free
                            owner     <= SRC_USER;
                            fe_cmd    <= usr_cmd;
                            fe_wdata  <= usr_wdata;
                            usr_grant <= 1'b1;
                        end else begin
                            owner    <= SRC_SCAN;
                            fe_cmd   <= scan_cmd(PHY_W'(scan_addr), SCAN_REG);
                            fe_wdata <= '0;
                        end
                    end
                end
                default: begin
                    // non-preemptive: hold until the frame engine finishes
                    if (fe_done) begin
                        owner <= SRC_NONE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/phy_scan_engine.sv
module phy_scan_engine
    import phy_scan_pkg::*;
#(
    parameter int NUM_ADDR = 32,
    parameter int DATA_W = 16,
    parameter logic [4:0] SCAN_REG = 5'd1,
    localparam int AW = $clog2(NUM_ADDR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                usr_req,
    input  logic                usr_write,
    input  logic [4:0]          usr_phy,
    input  logic [4:0]          usr_reg,
    input  logic [DATA_W-1:0]   usr_wdata,
    output logic                usr_grant,
    output logic                usr_done,
    output logic                usr_ack,
    output logic [DATA_W-1:0]   usr_rdata,
    output logic                fe_start,
    output logic                fe_write,
    output logic [4:0]          fe_phy,
    output logic [4:0]          fe_reg,
    output logic [DATA_W-1:0]   fe_wdata,
    input  logic                fe_done,
    input  logic                fe_ack,
    input  logic [DATA_W-1:0]   fe_rdata,
    output logic [NUM_ADDR-1:0] live_map,
    output logic                scan_resp,
    output logic [AW-1:0]       scan_resp_addr,
    output logic                idle
);

    cmd_t          usr_cmd;
    cmd_t          fe_cmd;
    src_e          owner;
    logic [AW-1:0] scan_addr;
    logic          scan_fin;
    logic          user_fin;

    assign usr_cmd  = '{wr: usr_write, phy: usr_phy, regad: usr_reg};
    assign fe_write = fe_cmd.wr;
    assign fe_phy   = fe_cmd.phy;
    assign fe_reg   = fe_cmd.regad;

    assign scan_fin = fe_done && (owner == SRC_SCAN);
    assign user_fin = fe_done && (owner == SRC_USER);
    assign idle     = (owner == SRC_NONE) && !enable;

    bus_arbiter #(
        .NUM_ADDR (NUM_ADDR),
        .DATA_W   (DATA_W),
        .SCAN_REG (SCAN_REG)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .usr_req   (usr_req),
        .usr_cmd   (usr_cmd),
        .usr_wdata (usr_wdata),
        .scan_addr (scan_addr),
        .fe_done   (fe_done),
        .fe_start  (fe_start),
        .fe_cmd    (fe_cmd),
        .fe_wdata  (fe_wdata),
        .usr_grant (usr_grant),
        .owner     (owner)
    );

    // position advances only after its own read finishes
    scan_addr_ctr #(.NUM_ADDR(NUM_ADDR)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .step (scan_fin),
        .addr (scan_addr)
    );

    live_bitmap #(.NUM_ADDR(NUM_ADDR)) u_map (
        .clk  (clk),
        .rst  (rst),
        .upd  (scan_fin),
        .idx  (scan_addr),
        .hit  (fe_ack),
        .bits (live_map)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            usr_done       <= 1'b0;
            usr_ack        <= 1'b0;
            usr_rdata      <= '0;
            scan_resp      <= 1'b0;
            scan_resp_addr <= '0;
        end else begin
            usr_done  <= user_fin;
            scan_resp <= scan_fin && fe_ack;
            if (user_fin) begin
                usr_ack   <= fe_ack;
                usr_rdata <= fe_rdata;
            end
            if (scan_fin) begin
                scan_resp_addr <= scan_addr;
            end
        end
    end

endmodule

// File: rtl/phy_scan_engine_chk.sv
module phy_scan_engine_chk #(
    parameter int NUM_ADDR = 32,
    localparam int AW = $clog2(NUM_ADDR)
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic                usr_grant,
    input logic                usr_done,
    input logic                fe_start,
    input logic                fe_done,
    input logic                fe_ack,
    input logic [NUM_ADDR-1:0] live_map,
    input logic                scan_resp,
    input logic [AW-1:0]       scan_resp_addr,
    input logic                idle
);

    logic inflight;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight <= 1'b0;
        end else if (fe_start) begin
            inflight <= 1'b1;
        end else if (fe_done) begin
            inflight <= 1'b0;
        end
    end

    a_r1_map_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (live_map == '0));

    a_r3_map_only_on_done: assert property (@(posedge clk) disable iff (rst)
        !$past(fe_done) |-> $stable(live_map));

    a_r4_resp_after_ack: assert property (@(posedge clk) disable iff (rst)
        scan_resp |-> $past(fe_done && fe_ack));

    a_r4_resp_marks_live: assert property (@(posedge clk) disable iff (rst)
        scan_resp |-> live_map[scan_resp_addr]);

    a_r5_single_txn: assert property (@(posedge clk) disable iff (rst)
        inflight |-> !fe_start);

    a_r8_grant_with_start: assert property (@(posedge clk) disable iff (rst)
        usr_grant |-> fe_start);

    a_r8_done_after_fe: assert property (@(posedge clk) disable iff (rst)
        usr_done |-> $past(fe_done));

    a_r9_no_start_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !fe_start);

    a_r9_busy_not_idle: assert property (@(posedge clk) disable iff (rst)
        fe_start |-> !idle);

endmodule

bind phy_scan_engine phy_scan_engine_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enable         (enable),
    .usr_grant      (usr_grant),
    .usr_done       (usr_done),
    .fe_start       (fe_start),
    .fe_done        (fe_done),
    .fe_ack         (fe_ack),
    .live_map       (live_map),
    .scan_resp      (scan_resp),
    .scan_resp_addr (scan_resp_addr),
    .idle           (idle)
);

// File: tb/sim_phy_scan_engine.sv
`timescale 1ns/1ps
module sim_phy_scan_engine;

    localparam int NUM_ADDR = 32;
    localparam int DATA_W = 16;
    localparam int AW = 5;
    localparam int LAT = 3;
    localparam logic [4:0] SCAN_REG = 5'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic usr_req = 1'b0;
    logic usr_write = 1'b0;
    logic [4:0] usr_phy = '0;
    logic [4:0] usr_reg = '0;
    logic [DATA_W-1:0] usr_wdata = '0;
    logic usr_grant, usr_done, usr_ack;
    logic [DATA_W-1:0] usr_rdata;
    logic fe_start, fe_write;
    logic [4:0] fe_phy, fe_reg;
    logic [DATA_W-1:0] fe_wdata;
    logic fe_done = 1'b0;
    logic fe_ack = 1'b0;
    logic [DATA_W-1:0] fe_rdata = '0;
    logic [NUM_ADDR-1:0] live_map;
    logic scan_resp;
    logic [AW-1:0] scan_resp_addr;
    logic idle;

    always #4 clk = ~clk;

    phy_scan_engine #(
        .NUM_ADDR (NUM_ADDR),
        .DATA_W   (DATA_W),
        .SCAN_REG (SCAN_REG)
    ) u0 (
        .clk(clk), .rst(rst), .enable(enable),
        .usr_req(usr_req), .usr_write(usr_write), .usr_phy(usr_phy),
        .usr_reg(usr_reg), .usr_wdata(usr_wdata),
        .usr_grant(usr_grant), .usr_done(usr_done), .usr_ack(usr_ack),
        .usr_rdata(usr_rdata),
        .fe_start(fe_start), .fe_write(fe_write), .fe_phy(fe_phy),
        .fe_reg(fe_reg), .fe_wdata(fe_wdata),
        .fe_done(fe_done), .fe_ack(fe_ack), .fe_rdata(fe_rdata),
        .live_map(live_map), .scan_resp(scan_resp),
        .scan_resp_addr(scan_resp_addr), .idle(idle)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] reg_val(logic [4:0] p, logic [4:0] r);
        return {p, r, 6'h15} ^ 16'hA5C3;
    endfunction

    // ---------------- frame engine model ----------------
    logic [NUM_ADDR-1:0] present = 32'h8000_4013;
    bit md_busy = 0;
    int md_cnt = 0;
    logic [4:0] md_phy, md_reg;
    logic md_wr;

    always @(negedge clk) begin
        fe_done = 1'b0;
        if (!rst) begin
            if (fe_start) begin
                // R5: no start while one is outstanding
                check("R5", "start while busy", md_busy, 0);
                md_busy = 1;
                md_cnt  = LAT;
                md_phy  = fe_phy;
                md_reg  = fe_reg;
                md_wr   = fe_write;
            end else if (md_busy) begin
                md_cnt--;
                if (md_cnt == 0) begin
                    md_busy  = 0;
                    fe_done  = 1'b1;
                    fe_ack   = present[md_phy];
                    fe_rdata = md_wr ? '0 : reg_val(md_phy, md_reg);
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic             wr;
        logic [4:0]       phy;
        logic [4:0]       rg;
        logic [DATA_W-1:0] wd;
    } uitem_t;

    uitem_t q[$];
    uitem_t cur_u;
    int exp_ptr = 0;
    int cur_src = 0;
    int cur_phy = 0;
    int scan_done_cnt = 0;
    int start_cnt = 0;
    logic [NUM_ADDR-1:0] exp_map = '0;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (fe_start) begin
                    start_cnt++;
                    if (q.size() > 0) begin
                        cur_u = q.pop_front();
                        check("R6", "grant for pending request", usr_grant, 1);
                        check("R8", "user write flag", fe_write, cur_u.wr);
                        check("R8", "user phy", fe_phy, cur_u.phy);
                        check("R8", "user reg", fe_reg, cur_u.rg);
                        if (cur_u.wr) check("R8", "user wdata", fe_wdata, cur_u.wd);
                        cur_src = 2;
                    end else begin
                        check("R6", "no grant for scan", usr_grant, 0);
                        check("R2", "scan address order", fe_phy, exp_ptr);
                        check("R2", "scan register", fe_reg, SCAN_REG);
                        check("R2", "scan is read", fe_write, 0);
                        cur_phy = exp_ptr;
                        exp_ptr = (exp_ptr + 1) % NUM_ADDR;
                        cur_src = 1;
                    end
                end
                if (fe_done) begin
                    if (cur_src == 1) begin
                        exp_map[cur_phy] = fe_ack;
                        scan_done_cnt++;
                        check("R3", "map after scan", live_map, exp_map);
                        check("R4", "scan_resp", scan_resp, fe_ack);
                        if (fe_ack) check("R4", "scan_resp_addr", scan_resp_addr, cur_phy);
                        check("R8", "no usr_done on scan", usr_done, 0);
                    end else if (cur_src == 2) begin
                        check("R8", "usr_done", usr_done, 1);
                        check("R8", "usr_ack", usr_ack, fe_ack);
                        if (!cur_u.wr && fe_ack)
                            check("R8", "usr_rdata", usr_rdata, reg_val(cur_u.phy, cur_u.rg));
                        check("R4", "no scan_resp on user", scan_resp, 0);
                        check("R3", "map held on user", live_map, exp_map);
                    end
                    cur_src = 0;
                end
            end
        end
    end

    // driver: call at a negedge; returns at the negedge where usr_done is seen
    task automatic user_access(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                               input logic [DATA_W-1:0] wd, output int wait_cyc);
        usr_write = wr;
        usr_phy   = phy;
        usr_reg   = rg;
        usr_wdata = wd;
        usr_req   = 1'b1;
        q.push_back('{wr, phy, rg, wd});
        wait_cyc = 0;
        do begin
            @(negedge clk);
            wait_cyc++;
        end while (!usr_grant && wait_cyc < 1000);
        usr_req = 1'b0;
        while (!usr_done && wait_cyc < 2000) begin
            @(negedge clk);
            wait_cyc++;
        end
    endtask

    task automatic wait_scans(int n);
        int target;
        target = scan_done_cnt + n;
        while (scan_done_cnt < target) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int wc;
        int base;
        int snap_starts;
        logic [NUM_ADDR-1:0] snap_map;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "live_map after reset", live_map, 0);
        check("R1", "idle after reset", idle, 1);
        check("R1", "fe_start after reset", fe_start, 0);
        repeat (10) @(negedge clk);
        check("R9", "no start while disabled", start_cnt, 0);

        // R10/R2: two full passes, including the 31 -> 0 wrap
        enable = 1'b1;
        wait_scans(NUM_ADDR);
        check("R10", "map after first pass", live_map, present);
        wait_scans(NUM_ADDR + 4);
        check("R2", "pointer wrapped", exp_ptr, 4);

        // R3: drop PHYs 0 and 31, add PHY 7
        present = 32'h0000_4092;
        wait_scans(NUM_ADDR);
        check("R3", "cleared bits after pass", live_map, present);
        check("R10", "map after changed pass", live_map, present);

        // R7: request raised just after a scan read begins
        do begin @(posedge clk); #1; end while (!(fe_start && !usr_grant));
        @(negedge clk);
        base = scan_done_cnt;
        user_access(1'b0, 5'd4, 5'd2, '0, wc);
        check("R7", "scan read finished before grant", scan_done_cnt, base + 1);
        check("R7", "deferral bounded", (wc <= LAT + 6) ? 1 : 0, 1);

        // R6: request raised as the previous software access ends
        base = start_cnt;
        user_access(1'b1, 5'd14, 5'd0, 16'h1234, wc);
        check("R6", "user next after user", start_cnt, base + 1);
        // R8: read of an absent PHY
        user_access(1'b0, 5'd9, 5'd3, '0, wc);
        check("R8", "absent phy no ack", usr_ack, 0);
        user_access(1'b0, 5'd1, 5'd5, '0, wc);
        check("R8", "present phy ack", usr_ack, 1);
        check("R8", "present phy data", usr_rdata, reg_val(5'd1, 5'd5));

        // R9: disable stops scanning
        wait_scans(3);
        enable = 1'b0;
        snap_starts = start_cnt;
        repeat (LAT + 4) @(negedge clk);
        snap_map = live_map;
        repeat (30) @(negedge clk);
        check("R9", "no starts while off", start_cnt, snap_starts);
        check("R9", "idle when off", idle, 1);
        check("R9", "map held when off", live_map, snap_map);

        // resume: scan continues from where it stopped (checked by scoreboard)
        enable = 1'b1;
        wait_scans(NUM_ADDR);
        check("R10", "map after resume pass", live_map, present);
        enable = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        check("R5", "queue drained", q.size(), 0);
        finish_run();
    end

endmodule